// File: doc/BRIEF.md
# Parallel LCD Power-Up Sequencer

This block brings a TFT panel controller out of power-up on its own, with no processor involved. A single `start` pulse begins the run. The block first pulses the panel's hardware reset line and waits for it to settle. It then sends a fixed script of 48 bus words over an 8080-style write-only parallel bus, using chip select, register-select, write strobe and a 16-bit data bus. The script covers PLL programming and lock, a soft reset, pixel clock, panel mode, horizontal and vertical timing, GPIO, pixel format, and finally display-on.

Each script word is either a command (register-select low) or a parameter (register-select high). Bytes sit in the low eight bits of the data bus, and the upper bits are zero. The panel-size and period parameters are not stored as constants. They are derived at elaboration from resolution, sync width and porch parameters, each as a value minus one, split into a high byte and a low byte. All delays are counted in system clocks, so the integrator scales them to the clock frequency.

Top module: `lcdInitSequencer`

## Requirements
- R1: After reset, `lcdRstN`, `lcdCsN` and `lcdWrN` are high, and `busy` and `done` are low.
- R2: After `start`, `lcdRstN` stays high for RST_PRE_CYC cycles, counted from the rise of `busy`. It is then low for exactly RST_LOW_CYC cycles. It is then high for SETTLE_CYC cycles before `lcdCsN` first falls. While `lcdRstN` is low, `lcdCsN` and `lcdWrN` stay high.
- R3: Every word's data and register-select are stable for at least one cycle before `lcdWrN` falls and for as long as it is low. `lcdWrN` is low for exactly STROBE_LOW_CYC cycles per word. Between two strobes with no programmed wait, it is high for STROBE_HIGH_CYC+1 cycles.
- R4: `lcdRs` is 0 for a command word and 1 for a parameter word. `lcdData[15:8]` is always zero.
- R5: The script order is fixed and is listed below. Each group is one command followed by its parameters.
  - E2 23 02 04
  - E0 01
  - E0 03
  - 01
  - E6 03 FF FF
  - B0 20 00 {H_RES-1} {V_RES-1} 00
  - B4 {HT-1} {HPW+HBP-1} {HPW-1} 00 00 00
  - B6 {VT-1} {VPW+VBP-1} {VPW-1} 00 00
  - BA 05
  - B8 07 01
  - 3A 55
  - F0 03
  - 29

  In total the script is 48 strobes.
- R6: Each braced value is a 16-bit quantity sent as its high byte and then its low byte, except the two single-byte width-minus-one fields. HT is H_RES+HPW+HBP+HFP, and VT is V_RES+VPW+VBP+VFP.
- R7: Some words are followed by extra high time on `lcdWrN`:
  - PLL_WAIT_CYC cycles after each of the two parameters of the E0 commands;
  - SRST_WAIT_CYC cycles after the 01 command;
  - FMT_WAIT_CYC cycles after the parameter of F0.
- R8: `lcdCsN` is low during every strobe and returns high after the last strobe. `busy` is high from start until the last strobe has completed, and `done` then rises. `busy` and `done` are never high together.
- R9: `start` is ignored while `busy` is high and after `done`. The script is never restarted, and `done` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up run (one-shot) |
| lcdRstN | output | 1 | Panel hardware reset, active low |
| lcdCsN | output | 1 | Bus chip select, active low |
| lcdWrN | output | 1 | Write strobe, active low |
| lcdRs | output | 1 | Register-select: 0 command, 1 parameter |
| lcdData | output | BUS_W | Write data bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete (sticky) |

## Verification
The embedded assertions check the cycle-local bus rules on every cycle:
- chip select is low whenever the strobe is low;
- data and register-select hold still while the strobe is low;
- the bus stays quiet during the reset pulse;
- the script index never moves under a low strobe;
- `busy` and `done` are exclusive, and `done` is sticky.

The bench checks what only a complete run can show:
- the exact word content and order, including the derived minus-one high and low bytes;
- the measured lengths of the reset, settle and strobe phases and of each programmed wait;
- that `start` pulses arriving mid-run or after completion leave the sequence unchanged.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;
  localparam int SCRIPT_LEN = 48;

  typedef enum logic [1:0] {WAIT_NONE, WAIT_PLL, WAIT_SRST, WAIT_FMT} waitKind_t;

  typedef struct packed {
    logic      isParam;
    logic [7:0] value;
    waitKind_t waitAfter;
  } scriptWord_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rstLow;
    logic csOn;
    logic wrLow;
    logic load;
    logic step;
    logic busy;
    logic done;
  } seqCtl_t;
endpackage

// File: rtl/lcdSeqCtrl.sv
module lcdSeqCtrl
  import lcdSeqPkg::*;
#(
  parameter int RST_PRE_CYC     = 8,
  parameter int RST_LOW_CYC     = 8,
  parameter int SETTLE_CYC      = 8,
  parameter int PLL_WAIT_CYC    = 8,
  parameter int SRST_WAIT_CYC   = 8,
  parameter int FMT_WAIT_CYC    = 8,
  parameter int STROBE_LOW_CYC  = 2,
  parameter int STROBE_HIGH_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  waitKind_t curWait,
  input  logic      curLast,
  output seqCtl_t   ctl
);
  localparam int M1 = (RST_PRE_CYC > RST_LOW_CYC) ? RST_PRE_CYC : RST_LOW_CYC;
  localparam int M2 = (SETTLE_CYC > PLL_WAIT_CYC) ? SETTLE_CYC : PLL_WAIT_CYC;
  localparam int M3 = (SRST_WAIT_CYC > FMT_WAIT_CYC) ? SRST_WAIT_CYC : FMT_WAIT_CYC;
  localparam int M4 = (STROBE_LOW_CYC > STROBE_HIGH_CYC) ? STROBE_LOW_CYC : STROBE_HIGH_CYC;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int M34 = (M3 > M4) ? M3 : M4;
  localparam int MAX_CYC = (M12 > M34) ? M12 : M34;
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RLOW, S_SETTLE, S_SETUP, S_WLOW, S_WHIGH, S_WAIT, S_DONE
  } seqState_t;

  seqState_t state, stateNext;
  logic [CW-1:0] cnt, curLimit;
  logic phaseEnd;

  always_comb begin
    unique case (state)
      S_PRE:    curLimit = CW'(RST_PRE_CYC);
      S_RLOW:   curLimit = CW'(RST_LOW_CYC);
      S_SETTLE: curLimit = CW'(SETTLE_CYC);
      S_WLOW:   curLimit = CW'(STROBE_LOW_CYC);
      S_WHIGH:  curLimit = CW'(STROBE_HIGH_CYC);
      S_WAIT: begin
        unique case (curWait)
          WAIT_PLL:  curLimit = CW'(PLL_WAIT_CYC);
          WAIT_SRST: curLimit = CW'(SRST_WAIT_CYC);
          WAIT_FMT:  curLimit = CW'(FMT_WAIT_CYC);
          default:   curLimit = CW'(1);
        endcase
      end
      default:  curLimit = CW'(1);
    endcase
    phaseEnd = (cnt == curLimit - CW'(1));
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (start) stateNext = S_PRE;
      S_PRE:    if (phaseEnd) stateNext = S_RLOW;
      S_RLOW:   if (phaseEnd) stateNext = S_SETTLE;
      S_SETTLE: if (phaseEnd) stateNext = S_SETUP;
      S_SETUP:  stateNext = S_WLOW;
      S_WLOW:   if (phaseEnd) stateNext = S_WHIGH;
      S_WHIGH:
        if (phaseEnd) begin
          if (curWait != WAIT_NONE) stateNext = S_WAIT;
          else if (curLast)         stateNext = S_DONE;
          else                      stateNext = S_SETUP;
        end
      S_WAIT:   if (phaseEnd) stateNext = curLast ? S_DONE : S_SETUP;
      default:  stateNext = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= (stateNext != state) ? '0 : cnt + CW'(1);
    end
  end

  always_comb begin
    ctl.rstLow = (state == S_RLOW);
    ctl.csOn   = (state == S_SETUP) || (state == S_WLOW) || (state == S_WHIGH) || (state == S_WAIT);
    ctl.wrLow  = (state == S_WLOW);
    ctl.load   = (state == S_SETUP);
    ctl.step   = (stateNext == S_SETUP) && (state != S_SETTLE);
    ctl.busy   = (state != S_IDLE) && (state != S_DONE);
    ctl.done   = (state == S_DONE);
  end

  // R7: a timed phase never runs past its programmed length
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_DONE && state != S_SETUP) |-> cnt < curLimit);
  // R9: completion is terminal
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |=> (state == S_DONE));
endmodule

// File: rtl/lcdSeqPath.sv
module lcdSeqPath
  import lcdSeqPkg::*;
#(
  parameter int BUS_W = 16,
  parameter int H_RES = 480,
  parameter int H_PW  = 41,
  parameter int H_BP  = 2,
  parameter int H_FP  = 2,
  parameter int V_RES = 272,
  parameter int V_PW  = 10,
  parameter int V_BP  = 2,
  parameter int V_FP  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  output waitKind_t        curWait,
  output logic             curLast,
  output logic             lcdRstN,
  output logic             lcdCsN,
  output logic             lcdWrN,
  output logic             lcdRs,
  output logic [BUS_W-1:0] lcdData,
  output logic             busy,
  output logic             done
);
  localparam int IDX_W = $clog2(SCRIPT_LEN);
  localparam logic [15:0] HRES_M1 = 16'(H_RES - 1);
  localparam logic [15:0] VRES_M1 = 16'(V_RES - 1);
  localparam logic [15:0] HTOT_M1 = 16'(H_RES + H_PW + H_BP + H_FP - 1);
  localparam logic [15:0] HST_M1  = 16'(H_PW + H_BP - 1);
  localparam logic [7:0]  HPW_M1  = 8'(H_PW - 1);
  localparam logic [15:0] VTOT_M1 = 16'(V_RES + V_PW + V_BP + V_FP - 1);
  localparam logic [15:0] VST_M1  = 16'(V_PW + V_BP - 1);
  localparam logic [7:0]  VPW_M1  = 8'(V_PW - 1);

  function automatic scriptWord_t cmdW(input logic [7:0] v, input waitKind_t w);
    return '{isParam: 1'b0, value: v, waitAfter: w};
  endfunction
  function automatic scriptWord_t prmW(input logic [7:0] v, input waitKind_t w);
    return '{isParam: 1'b1, value: v, waitAfter: w};
  endfunction

  function automatic scriptWord_t scriptAt(input logic [IDX_W-1:0] i);
    unique case (i)
      6'd0:  return cmdW(8'hE2, WAIT_NONE);
      6'd1:  return prmW(8'h23, WAIT_NONE);
      6'd2:  return prmW(8'h02, WAIT_NONE);
      6'd3:  return prmW(8'h04, WAIT_NONE);
      6'd4:  return cmdW(8'hE0, WAIT_NONE);
      6'd5:  return prmW(8'h01, WAIT_PLL);
      6'd6:  return cmdW(8'hE0, WAIT_NONE);
      6'd7:  return prmW(8'h03, WAIT_PLL);
      6'd8:  return cmdW(8'h01, WAIT_SRST);
      6'd9:  return cmdW(8'hE6, WAIT_NONE);
      6'd10: return prmW(8'h03, WAIT_NONE);
      6'd11: return prmW(8'hFF, WAIT_NONE);
      6'd12: return prmW(8'hFF, WAIT_NONE);
      6'd13: return cmdW(8'hB0, WAIT_NONE);
      6'd14: return prmW(8'h20, WAIT_NONE);
      6'd15: return prmW(8'h00, WAIT_NONE);
      6'd16: return prmW(HRES_M1[15:8], WAIT_NONE);
      6'd17: return prmW(HRES_M1[7:0], WAIT_NONE);
      6'd18: return prmW(VRES_M1[15:8], WAIT_NONE);
      6'd19: return prmW(VRES_M1[7:0], WAIT_NONE);
      6'd20: return prmW(8'h00, WAIT_NONE);
      6'd21: return cmdW(8'hB4, WAIT_NONE);
      6'd22: return prmW(HTOT_M1[15:8], WAIT_NONE);
      6'd23: return prmW(HTOT_M1[7:0], WAIT_NONE);
      6'd24: return prmW(HST_M1[15:8], WAIT_NONE);
      6'd25: return prmW(HST_M1[7:0], WAIT_NONE);
      6'd26: return prmW(HPW_M1, WAIT_NONE);
      6'd27: return prmW(8'h00, WAIT_NONE);
      6'd28: return prmW(8'h00, WAIT_NONE);
      6'd29: return prmW(8'h00, WAIT_NONE);
      6'd30: return cmdW(8'hB6, WAIT_NONE);
      6'd31: return prmW(VTOT_M1[15:8], WAIT_NONE);
      6'd32: return prmW(VTOT_M1[7:0], WAIT_NONE);
      6'd33: return prmW(VST_M1[15:8], WAIT_NONE);
      6'd34: return prmW(VST_M1[7:0], WAIT_NONE);
      6'd35: return prmW(VPW_M1, WAIT_NONE);
      6'd36: return prmW(8'h00, WAIT_NONE);
      6'd37: return prmW(8'h00, WAIT_NONE);
      6'd38: return cmdW(8'hBA, WAIT_NONE);
      6'd39: return prmW(8'h05, WAIT_NONE);
      6'd40: return cmdW(8'hB8, WAIT_NONE);
      6'd41: return prmW(8'h07, WAIT_NONE);
      6'd42: return prmW(8'h01, WAIT_NONE);
      6'd43: return cmdW(8'h3A, WAIT_NONE);
      6'd44: return prmW(8'h55, WAIT_NONE);
      6'd45: return cmdW(8'hF0, WAIT_NONE);
      6'd46: return prmW(8'h03, WAIT_FMT);
      default: return cmdW(8'h29, WAIT_NONE);
    endcase
  endfunction

  logic [IDX_W-1:0] idxQ;
  scriptWord_t curWord;

  assign curWord = scriptAt(idxQ);
  assign curWait = curWord.waitAfter;
  assign curLast = (idxQ == IDX_W'(SCRIPT_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ    <= '0;
      lcdRstN <= 1'b1;
      lcdCsN  <= 1'b1;
      lcdWrN  <= 1'b1;
      lcdRs   <= 1'b0;
      lcdData <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (ctl.step) idxQ <= idxQ + IDX_W'(1);
      if (ctl.load) begin
        lcdRs   <= curWord.isParam;
        lcdData <= BUS_W'(curWord.value);
      end
      lcdRstN <= !ctl.rstLow;
      lcdCsN  <= !ctl.csOn;
      lcdWrN  <= !ctl.wrLow;
      busy    <= ctl.busy;
      done    <= ctl.done;
    end
  end

  // R8: strobe only inside chip select
  p_cs_on_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> !lcdCsN);
  // R3: bus held while strobe low
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> ($stable(lcdData) && $stable(lcdRs)));
  // R2: no bus traffic during panel reset
  p_quiet_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lcdRstN |-> (lcdCsN && lcdWrN));
  // R8: busy and done exclusive
  p_busy_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  // R5: script position never moves under a low strobe
  p_idx_move_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idxQ) |-> lcdWrN);
endmodule

// File: rtl/lcdInitSequencer.sv
module lcdInitSequencer
  import lcdSeqPkg::*;
#(
  parameter int BUS_W           = 16,
  parameter int H_RES           = 480,
  parameter int H_PW            = 41,
  parameter int H_BP            = 2,
  parameter int H_FP            = 2,
  parameter int V_RES           = 272,
  parameter int V_PW            = 10,
  parameter int V_BP            = 2,
  parameter int V_FP            = 2,
  parameter int RST_PRE_CYC     = 500000,
  parameter int RST_LOW_CYC     = 1500000,
  parameter int SETTLE_CYC      = 1500000,
  parameter int PLL_WAIT_CYC    = 100000,
  parameter int SRST_WAIT_CYC   = 100000,
  parameter int FMT_WAIT_CYC    = 100000,
  parameter int STROBE_LOW_CYC  = 100,
  parameter int STROBE_HIGH_CYC = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             lcdRstN,
  output logic             lcdCsN,
  output logic             lcdWrN,
  output logic             lcdRs,
  output logic [BUS_W-1:0] lcdData,
  output logic             busy,
  output logic             done
);
  seqCtl_t   ctl;
  waitKind_t curWait;
  logic      curLast;

  lcdSeqCtrl #(
    .RST_PRE_CYC(RST_PRE_CYC), .RST_LOW_CYC(RST_LOW_CYC), .SETTLE_CYC(SETTLE_CYC),
    .PLL_WAIT_CYC(PLL_WAIT_CYC), .SRST_WAIT_CYC(SRST_WAIT_CYC), .FMT_WAIT_CYC(FMT_WAIT_CYC),
    .STROBE_LOW_CYC(STROBE_LOW_CYC), .STROBE_HIGH_CYC(STROBE_HIGH_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .curWait(curWait), .curLast(curLast), .ctl(ctl)
  );

  lcdSeqPath #(
    .BUS_W(BUS_W), .H_RES(H_RES), .H_PW(H_PW), .H_BP(H_BP), .H_FP(H_FP),
    .V_RES(V_RES), .V_PW(V_PW), .V_BP(V_BP), .V_FP(V_FP)
  ) path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curWait(curWait), .curLast(curLast),
    .lcdRstN(lcdRstN), .lcdCsN(lcdCsN), .lcdWrN(lcdWrN), .lcdRs(lcdRs),
    .lcdData(lcdData), .busy(busy), .done(done)
  );
endmodule

// File: tb/lcdInitSequencer_test.sv
module lcdInitSequencer_test;
  localparam int H_RES = 300, H_PW = 2, H_BP = 3, H_FP = 4;
  localparam int V_RES = 272, V_PW = 3, V_BP = 2, V_FP = 1;
  localparam int PRE = 5, RLOW = 7, SETTLE = 6, PLLW = 9, SRSTW = 11, FMTW = 4;
  localparam int SL = 3, SH = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic lcdRstN, lcdCsN, lcdWrN, lcdRs, busy, done;
  logic [15:0] lcdData;

  lcdInitSequencer #(
    .BUS_W(16), .H_RES(H_RES), .H_PW(H_PW), .H_BP(H_BP), .H_FP(H_FP),
    .V_RES(V_RES), .V_PW(V_PW), .V_BP(V_BP), .V_FP(V_FP),
    .RST_PRE_CYC(PRE), .RST_LOW_CYC(RLOW), .SETTLE_CYC(SETTLE),
    .PLL_WAIT_CYC(PLLW), .SRST_WAIT_CYC(SRSTW), .FMT_WAIT_CYC(FMTW),
    .STROBE_LOW_CYC(SL), .STROBE_HIGH_CYC(SH)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .lcdRstN(lcdRstN), .lcdCsN(lcdCsN),
    .lcdWrN(lcdWrN), .lcdRs(lcdRs), .lcdData(lcdData), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // expected script: {rs, byte}
  function automatic int expWord(input int i);
    int ht, hs, vt, vs;
    ht = H_RES + H_PW + H_BP + H_FP - 1; hs = H_PW + H_BP - 1;
    vt = V_RES + V_PW + V_BP + V_FP - 1; vs = V_PW + V_BP - 1;
    case (i)
      0: return 'hE2; 1: return 'h123; 2: return 'h102; 3: return 'h104;
      4: return 'hE0; 5: return 'h101; 6: return 'hE0; 7: return 'h103;
      8: return 'h01; 9: return 'hE6; 10: return 'h103; 11: return 'h1FF; 12: return 'h1FF;
      13: return 'hB0; 14: return 'h120; 15: return 'h100;
      16: return 'h100 | ((H_RES - 1) >> 8); 17: return 'h100 | ((H_RES - 1) & 255);
      18: return 'h100 | ((V_RES - 1) >> 8); 19: return 'h100 | ((V_RES - 1) & 255);
      20: return 'h100; 21: return 'hB4;
      22: return 'h100 | (ht >> 8); 23: return 'h100 | (ht & 255);
      24: return 'h100 | (hs >> 8); 25: return 'h100 | (hs & 255);
      26: return 'h100 | (H_PW - 1); 27, 28, 29: return 'h100;
      30: return 'hB6;
      31: return 'h100 | (vt >> 8); 32: return 'h100 | (vt & 255);
      33: return 'h100 | (vs >> 8); 34: return 'h100 | (vs & 255);
      35: return 'h100 | (V_PW - 1); 36, 37: return 'h100;
      38: return 'hBA; 39: return 'h105; 40: return 'hB8; 41: return 'h107; 42: return 'h101;
      43: return 'h3A; 44: return 'h155; 45: return 'hF0; 46: return 'h103;
      default: return 'h29;
    endcase
  endfunction

  function automatic int waitAfter(input int i);
    if (i == 5 || i == 7) return PLLW;
    if (i == 8) return SRSTW;
    if (i == 46) return FMTW;
    return 0;
  endfunction

  int nStrobe = 0, lowRun = 0, highRun = 0, cyc = 0;
  int busyRise = -1, rstFall = -1, rstRise = -1, csFall = -1;
  int gotWord [0:63];
  logic prevWr = 1'b1, prevRst = 1'b1, prevCs = 1'b1, prevBusy = 1'b0, monOn = 1'b0;
  logic [16:0] prevBus = '0;

  always @(negedge clk) begin
    if (monOn) begin
      cyc++;
      if (!prevBusy && busy && busyRise < 0) busyRise = cyc;
      if (prevRst && !lcdRstN && rstFall < 0) rstFall = cyc;
      if (!prevRst && lcdRstN && rstRise < 0) rstRise = cyc;
      if (prevCs && !lcdCsN && csFall < 0) csFall = cyc;
      if (prevWr && !lcdWrN) begin
        chk({lcdRs, lcdData} == prevBus, "R3 data setup before strobe", int'(prevBus), int'({lcdRs, lcdData}));
        chk(!lcdCsN, "R8 cs low during strobe", int'(lcdCsN), 0);
        chk(lcdData[15:8] == 8'h00, "R4 upper byte zero", int'(lcdData[15:8]), 0);
        if (nStrobe > 0 && nStrobe < 64)
          chk(highRun == SH + 1 + waitAfter(nStrobe - 1), "R7 gap before strobe",
              highRun, SH + 1 + waitAfter(nStrobe - 1));
        if (nStrobe < 64) gotWord[nStrobe] = int'({lcdRs, lcdData[7:0]});
        nStrobe++;
        lowRun = 1;
      end else if (!lcdWrN) lowRun++;
      if (!prevWr && lcdWrN) begin
        chk(lowRun == SL, "R3 strobe low width", lowRun, SL);
        highRun = 1;
      end else if (lcdWrN && nStrobe > 0) highRun++;
      prevWr = lcdWrN; prevRst = lcdRstN; prevCs = lcdCsN; prevBusy = busy;
      prevBus = {lcdRs, lcdData};
    end
  end

  initial begin
    bit timedOut = 1'b0;
    repeat (3) @(negedge clk);
    chk(lcdRstN && lcdCsN && lcdWrN, "R1 bus idle in reset", int'({lcdRstN, lcdCsN, lcdWrN}), 7);
    chk(!busy && !done, "R1 status clear in reset", int'({busy, done}), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && lcdRstN, "R1 idle before start", int'({busy, done, lcdRstN}), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    // pulse start mid-run; it must be ignored (R9)
    for (int w = 0; w < 100000 && nStrobe < 20; w++) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      int w;
      for (w = 0; w < 100000 && !done; w++) @(negedge clk);
      if (!done) timedOut = 1'b1;
    end
    chk(!timedOut, "watchdog run completes", int'(timedOut), 0);
    chk(rstFall - busyRise == PRE, "R2 pre-reset high time", rstFall - busyRise, PRE);
    chk(rstRise - rstFall == RLOW, "R2 reset low time", rstRise - rstFall, RLOW);
    chk(csFall - rstRise == SETTLE, "R2 settle before bus", csFall - rstRise, SETTLE);
    chk(nStrobe == 48, "R5 strobe count", nStrobe, 48);
    for (int i = 0; i < 48 && i < nStrobe; i++) begin
      if (i >= 16 && i <= 35)
        chk(gotWord[i] == expWord(i), "R6 derived word", gotWord[i], expWord(i));
      else
        chk(gotWord[i] == expWord(i), "R5 R4 script word", gotWord[i], expWord(i));
    end
    chk(lcdCsN && !busy && done, "R8 end state", int'({lcdCsN, busy, done}), 5);
    // start after done has no effect (R9)
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (200) @(negedge clk);
    chk(nStrobe == 48, "R9 no restart after done", nStrobe, 48);
    chk(done && !busy && lcdRstN && lcdCsN, "R9 done sticky", int'({done, busy, lcdRstN, lcdCsN}), 11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule